// File: doc/BRIEF.md
# CPU clock and reset sequencer

This block derives a processor clock from a fast system clock and controls the processor's active-low reset line. The reset output is low from power-on. It stays low until an oscillator-ready level has been seen and passed through a synchronizer. At that point the block captures a 3-bit divider code and starts the processor clock. A hold timer then runs for a parameterised number of system clock cycles. When the timer reaches zero, the reset output goes high. With a 32 MHz system clock, the default hold of 640,000 cycles gives about 20 ms.

The divider code n selects a processor clock of the system clock divided by 2^n. Codes 0 and 7 are clamped to the nearest legal code. The clock comes straight from one bit of a binary counter, so its high and low phases are always the same length. A completion flag rises together with the reset release. The released state can only be cleared by the asynchronous power-on reset.

Top module: `cpu_clk_rst_seq`

## Requirements
- R1: While rst_ni is low, cpu_rst_no, cpu_clk_o and seq_done_o are all low.
- R2: Until osc_ready_i has been sampled high, cpu_clk_o stays low without toggling and cpu_rst_no stays low.
- R3: osc_ready_i passes through a two-flop synchronizer. If it is driven high between two edges, cpu_rst_no first reads high after the (HOLD_CYCLES+3)-th rising clock edge from that point.
- R4: With a captured code n in the range 1 to 6, cpu_clk_o has a period of 2^n system clock cycles.
- R5: cpu_clk_o is high for exactly 2^(n-1) cycles and low for exactly 2^(n-1) cycles at every setting.
- R6: Divider code 0 behaves as code 1 (half period 1 cycle). Code 7 behaves as code 6 (half period 32 cycles).
- R7: div_sel_i is captured on the edge that enables the clock. A change made later, during the hold or after release, leaves the cpu_clk_o period unchanged.
- R8: Once cpu_rst_no is high, it stays high even if osc_ready_i falls, until rst_ni is asserted. seq_done_o is high exactly when cpu_rst_no is high.
- R9: cpu_clk_o is already toggling during the hold, while cpu_rst_no is still low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast system clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| osc_ready_i | input | 1 | Oscillator-ready level, asynchronous |
| div_sel_i | input | 3 | Divider code n, clock = clk_i / 2^n |
| cpu_clk_o | output | 1 | Divided processor clock, 50% duty |
| cpu_rst_no | output | 1 | Active-low processor reset |
| seq_done_o | output | 1 | High once reset has been released |

## Verification
The assertions assume three things about the inputs. rst_ni is asserted once with a falling edge before any checked edge. div_sel_i holds a single value for each capture. After the first toggle, every run of cpu_clk_o is a power of two no longer than 32 cycles, which holds only if the captured code never changes within one reset epoch. The bench keeps to these assumptions. It drives all inputs just after the falling clock edge and opens each scenario with a full reset. It changes div_sel_i only after the capture edge, so it can show that such a change is ignored. It lowers osc_ready_i only after release.

// File: rtl/cks_pkg.sv
package cks_pkg;
  localparam int unsigned CODE_W  = 3;
  localparam int unsigned DIV_MIN = 1;
  localparam int unsigned DIV_MAX = 6;

  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_HOLD = 2'd1,
    ST_RUN  = 2'd2
  } seq_state_e;

  function automatic logic [CODE_W-1:0] clamp_code(input logic [CODE_W-1:0] c);
    if (c < CODE_W'(DIV_MIN)) return CODE_W'(DIV_MIN);
    if (c > CODE_W'(DIV_MAX)) return CODE_W'(DIV_MAX);
    return c;
  endfunction
endpackage

// File: rtl/cks_sync.sv
module cks_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[s] <= 1'b0;
      else if (s == 0) chain_q[s] <= d_i;
      else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cks_pow2_div.sv
module cks_pow2_div
  import cks_pkg::*;
#(
  parameter int unsigned MAX_CODE = DIV_MAX
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [CODE_W-1:0] code_i,   // already clamped to 1..MAX_CODE
  output logic              clk_o
);
  logic [MAX_CODE-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (!en_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  // one counter bit: equal high and low phases, no decode glitch
  assign clk_o = cnt_q[code_i - 1'b1];
endmodule

// File: rtl/cks_hold_timer.sv
module cks_hold_timer #(
  parameter int unsigned HOLD_CYCLES = 640000,
  localparam int unsigned W = $clog2(HOLD_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic run_i,
  output logic zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= W'(HOLD_CYCLES - 1);
    else if (run_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/cpu_clk_rst_seq.sv
module cpu_clk_rst_seq
  import cks_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 640000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              osc_ready_i,
  input  logic [CODE_W-1:0] div_sel_i,
  output logic              cpu_clk_o,
  output logic              cpu_rst_no,
  output logic              seq_done_o
);
  seq_state_e        state_q;
  logic [CODE_W-1:0] code_q;
  logic              clk_en_q, rel_q;
  logic              ready_s, hold_zero, hold_load, hold_run;

  cks_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (osc_ready_i),
    .q_o   (ready_s)
  );

  assign hold_load = (state_q == ST_WAIT) && ready_s;
  assign hold_run  = (state_q == ST_HOLD);

  cks_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(hold_load),
    .run_i (hold_run),
    .zero_o(hold_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_WAIT;
      code_q   <= CODE_W'(DIV_MIN);
      clk_en_q <= 1'b0;
      rel_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_WAIT: if (ready_s) begin
          state_q  <= ST_HOLD;
          code_q   <= clamp_code(div_sel_i);  // captured once per reset
          clk_en_q <= 1'b1;
        end
        ST_HOLD: if (hold_zero) begin
          state_q <= ST_RUN;
          rel_q   <= 1'b1;
        end
        ST_RUN:  state_q <= ST_RUN;
        default: state_q <= ST_WAIT;
      endcase
    end
  end

  cks_pow2_div #(.MAX_CODE(DIV_MAX)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (clk_en_q),
    .code_i(code_q),
    .clk_o (cpu_clk_o)
  );

  assign cpu_rst_no = rel_q;
  assign seq_done_o = rel_q;
endmodule

// File: rtl/cks_seq_chk.sv
module cks_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       osc_ready_i,
  input logic [2:0] div_sel_i,
  input logic       cpu_clk_o,
  input logic       cpu_rst_no,
  input logic       seq_done_o
);
  logic       seen_q, prev_q, tog_q;
  logic [7:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      prev_q <= 1'b0;
      tog_q  <= 1'b0;
      run_q  <= 8'd0;
    end else begin
      seen_q <= seen_q | osc_ready_i;
      prev_q <= cpu_clk_o;
      tog_q  <= tog_q | (cpu_clk_o != prev_q);
      run_q  <= (cpu_clk_o != prev_q) ? 8'd1 : run_q + 8'd1;
    end
  end

  // R1
  reset_low_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!cpu_rst_no && !cpu_clk_o && !seq_done_o));

  // R2
  idle_before_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> (!cpu_clk_o && !cpu_rst_no));

  // R5
  even_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tog_q && cpu_clk_o != prev_q) |-> ($countones(run_q) == 1 && run_q <= 8'd32));

  // R8
  release_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rst_no |=> (cpu_rst_no && seq_done_o));
endmodule

bind cpu_clk_rst_seq cks_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .osc_ready_i(osc_ready_i),
  .div_sel_i  (div_sel_i),
  .cpu_clk_o  (cpu_clk_o),
  .cpu_rst_no (cpu_rst_no),
  .seq_done_o (seq_done_o)
);

// File: tb/cpu_clk_rst_seq_bench.sv
`timescale 1ns/1ps
module cpu_clk_rst_seq_bench;
  localparam int unsigned HOLD = 200;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b1;
  logic       osc_ready_i = 1'b0;
  logic [2:0] div_sel_i = 3'd1;
  logic       cpu_clk_o, cpu_rst_no, seq_done_o;

  int total = 0;
  int bad   = 0;

  always #2 clk_i = ~clk_i;

  cpu_clk_rst_seq #(.HOLD_CYCLES(HOLD)) u_cpu_clk_rst_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .osc_ready_i(osc_ready_i),
    .div_sel_i  (div_sel_i),
    .cpu_clk_o  (cpu_clk_o),
    .cpu_rst_no (cpu_rst_no),
    .seq_done_o (seq_done_o)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply_reset(input logic [2:0] code);
    @(negedge clk_i);
    rst_ni = 1'b0;
    osc_ready_i = 1'b0;
    div_sel_i = code;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  // returns number of posedges from ready raise until release is seen
  task automatic start_seq(output int edges, output bit clk_in_hold);
    edges = 0;
    clk_in_hold = 0;
    @(negedge clk_i);
    osc_ready_i = 1'b1;
    while (edges < HOLD + 20) begin
      @(posedge clk_i);
      edges++;
      @(negedge clk_i);
      if (cpu_rst_no) break;
      if (cpu_clk_o) clk_in_hold = 1;
    end
  endtask

  task automatic measure(output int hi, output int lo);
    int guard;
    hi = 0; lo = 0; guard = 0;
    while (cpu_clk_o && guard < 200) begin @(negedge clk_i); guard++; end
    while (!cpu_clk_o && guard < 200) begin @(negedge clk_i); guard++; end
    while (cpu_clk_o && guard < 400) begin hi++; @(negedge clk_i); guard++; end
    while (!cpu_clk_o && guard < 600) begin lo++; @(negedge clk_i); guard++; end
  endtask

  task automatic t_reset_state;
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R1 rst", int'(cpu_rst_no), 0);
    check("R1 clk", int'(cpu_clk_o), 0);
    check("R1 done", int'(seq_done_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_wait_osc;
    int hits = 0;
    apply_reset(3'd1);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i);
      if (cpu_clk_o || cpu_rst_no || seq_done_o) hits++;
    end
    check("R2 idle without ready", hits, 0);
  endtask

  task automatic t_release(input logic [2:0] code, input int exp_half, input string tag);
    int e, hi, lo;
    bit tog;
    apply_reset(code);
    start_seq(e, tog);
    check("R3 release edges", e, HOLD + 3);
    check("R8 done with release", int'(seq_done_o), 1);
    check("R9 clock runs in hold", int'(tog), 1);
    measure(hi, lo);
    check({tag, " high"}, hi, exp_half);
    check({tag, " low"}, lo, exp_half);
  endtask

  task automatic t_sel_change;
    int e, hi, lo;
    bit tog;
    apply_reset(3'd3);
    @(negedge clk_i);
    osc_ready_i = 1'b1;
    repeat (10) @(negedge clk_i);
    div_sel_i = 3'd5;                 // during hold
    start_seq(e, tog);
    div_sel_i = 3'd1;                 // after release
    measure(hi, lo);
    check("R7 high kept", hi, 4);
    check("R7 low kept", lo, 4);
  endtask

  task automatic t_sticky;
    int e, drops;
    bit tog;
    drops = 0;
    apply_reset(3'd2);
    start_seq(e, tog);
    osc_ready_i = 1'b0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk_i);
      if (!cpu_rst_no || !seq_done_o) drops++;
    end
    check("R8 release sticky", drops, 0);
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R1 rst reasserted", int'(cpu_rst_no), 0);
    rst_ni = 1'b1;
  endtask

  initial begin
    #1 rst_ni = 1'b0;
    #5 rst_ni = 1'b1;
    t_reset_state();
    t_wait_osc();
    for (int n = 1; n <= 6; n++)
      t_release(3'(n), 1 << (n - 1), "R4 R5 divide");
    t_release(3'd0, 1, "R6 code0");
    t_release(3'd7, 32, "R6 code7");
    t_sel_change();
    t_sticky();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule